// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one SDRAM column command into its per-beat timing. When a read or write strobe arrives with a start column, it produces a column address on every beat of the burst. The burst runs for the programmed length and follows either the sequential or the interleaved wrap order. Write beats are accepted in the same cycles as the column addresses, starting with the command cycle itself. Read beats come back as a data-valid strobe that is delayed by the programmed CAS latency.

The data mask acts differently for the two directions. On a write it marks the beat of the same cycle as masked. On a read it drops the output enable of the data that appears two cycles later. A new command may cut a running burst short on any cycle and restart from a new column. Read data already in flight still emerges on schedule.

The block is meant to sit between a memory controller's command scheduler and its data path. Burst length, burst type and CAS latency come from the controller's mode settings. CAS latency is treated as static while reads are in flight.

Top module: `sdram_burst_seq`

## Requirements
- R1: While `rst_n` is low and after reset with no command, `col_valid`, `wr_accept`, `wr_mask`, `rd_valid` and `rd_oe` are 0 and `col_addr` is 0.
- R2: A write command produces beat 0 in the command cycle: `col_valid`=1, `wr_accept`=1 and `col_addr`=`start_col`. Further beats follow on consecutive cycles until the burst length is reached, then `col_valid` and `wr_accept` return to 0.
- R3: In sequential order (`burst_il`=0), beat k addresses the aligned block of BL columns that holds the start column. Its offset inside that block is (start offset + k) mod BL.
- R4: In interleaved order (`burst_il`=1) with BL of 2, 4 or 8, beat k addresses `start_col` XOR k.
- R5: `bl_code`=7 selects a full-page burst. It counts upward from `start_col`, wraps from column 511 to 0, and continues until a new command arrives. Interleaved order is ignored for a full page.
- R6: `bl_code` 0, 1, 2 and 3 select BL 1, 2, 4 and 8. Codes 4, 5 and 6 behave as BL=1.
- R7: With `cas_lat`=0 (CAS latency 2) or `cas_lat`=1 (CAS latency 3), `rd_valid` is 1 exactly in those cycles that lie 2 or 3 cycles after a read beat.
- R8: A read or write command issued during a running burst ends it at once. The new burst starts in that same cycle from its own start column; commands may be 1 cycle apart.
- R9: During a write beat, `wr_mask` equals `dqm` of the same cycle. Outside write beats it is 0.
- R10: `rd_oe` is 1 in a `rd_valid` cycle exactly when `dqm` was 0 two cycles earlier. Outside `rd_valid` cycles it is 0.
- R11: If `cmd_rd` and `cmd_wr` are both 1 in one cycle, the command is taken as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_rd | input | 1 | Read column command strobe |
| cmd_wr | input | 1 | Write column command strobe |
| start_col | input | 9 | Start column of the new burst |
| bl_code | input | 3 | Burst length select (0:1, 1:2, 2:4, 3:8, 7:page, others:1) |
| burst_il | input | 1 | 1 = interleaved order, 0 = sequential |
| cas_lat | input | 1 | 0 = CAS latency 2, 1 = CAS latency 3 |
| dqm | input | 1 | Data mask / read output disable |
| col_valid | output | 1 | A burst beat is issued this cycle |
| col_addr | output | 9 | Column address of the current beat |
| wr_accept | output | 1 | Write data beat is taken this cycle |
| wr_mask | output | 1 | Current write beat is masked |
| rd_valid | output | 1 | Read data beat is valid this cycle |
| rd_oe | output | 1 | Read data output enable |

## Verification
The sequencer is driven with sequential bursts from unaligned start columns, so a wrong block alignment or a plain increment shows up. Interleaved bursts of length 4 and 8 separate an XOR order from an additive one. A full-page burst is started three columns below the top of the page to exercise the wrap to column 0, and is then cut off by a read. Chains of reads and writes spaced 1 and 2 cycles apart show whether a new command restarts cleanly while older read data still emerges. The same read burst is repeated at both CAS latencies, and scheduled mask pulses are placed inside write bursts and ahead of read data, which checks the two mask latencies apart.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
// Shared types and decoding for the SDRAM burst column sequencer.
// Assumes the burst length code is a 3-bit mode field.
package sbs_pkg;

    localparam logic [2:0] BLC_1    = 3'd0;
    localparam logic [2:0] BLC_2    = 3'd1;
    localparam logic [2:0] BLC_4    = 3'd2;
    localparam logic [2:0] BLC_8    = 3'd3;
    localparam logic [2:0] BLC_PAGE = 3'd7;

    // Per-burst settings captured at the command
    typedef struct packed {
        logic       is_wr;
        logic       ilv;
        logic       page;
        logic [1:0] len_log;
    } burst_cfg_t;

    // Map the mode fields of a command onto the captured burst settings
    function automatic burst_cfg_t decode_cfg(input logic [2:0] code,
                                              input logic       ilv,
                                              input logic       wr);
        burst_cfg_t c;
        c.is_wr   = wr;
        c.ilv     = ilv;
        c.page    = 1'b0;
        c.len_log = 2'd0;
        case (code)
            BLC_1:    c.len_log = 2'd0;
            BLC_2:    c.len_log = 2'd1;
            BLC_4:    c.len_log = 2'd2;
            BLC_8:    c.len_log = 2'd3;
            BLC_PAGE: c.page    = 1'b1;
            default:  c.len_log = 2'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sbs_beat_ctl.sv
`timescale 1ns/1ps
// Beat controller: tracks the running burst and its beat index.
// A new command takes over in its own cycle; write wins over read.
// Assumes mode inputs are only sampled in the command cycle.
module sbs_beat_ctl
    import sbs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             burst_il,
    output logic             beat_act,
    output logic [COL_W-1:0] beat_idx,
    output logic [COL_W-1:0] beat_base,
    output burst_cfg_t       beat_cfg
);

    logic             run_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] base_q;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] last_idx;
    logic             is_last;

    // Select the new command or the running burst for this cycle
    always_comb begin
        if (cmd_rd || cmd_wr) begin
            beat_act  = 1'b1;
            beat_idx  = '0;
            beat_base = start_col;
            beat_cfg  = decode_cfg(bl_code, burst_il, cmd_wr);
        end else begin
            beat_act  = run_q;
            beat_idx  = cnt_q;
            beat_base = base_q;
            beat_cfg  = cfg_q;
        end
        last_idx = COL_W'((32'd1 << beat_cfg.len_log) - 32'd1);
        is_last  = !beat_cfg.page && (beat_idx == last_idx);
    end

    // Advance the beat counter and hold the burst settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            base_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (beat_act && !is_last) begin
                run_q <= 1'b1;
                cnt_q <= beat_idx + COL_W'(1);
            end else begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end
            base_q <= beat_base;
            cfg_q  <= beat_cfg;
        end
    end

endmodule

// File: rtl/sbs_addr_gen.sv
`timescale 1ns/1ps
// Column address generator: combines start column and beat index
// in sequential (aligned wrap) or interleaved (XOR) order.
// A full page always counts sequentially around the whole page.
module sbs_addr_gen #(
    parameter int COL_W  = 9,
    parameter bit ILV_EN = 1'b1
) (
    input  logic             act,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic             ilv,
    input  logic             page,
    input  logic [1:0]       len_log,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;
    logic             use_ilv;

    // Wrap mask and sequential address inside the aligned block
    always_comb begin
        wrap_mask = page ? '1 : COL_W'((32'd1 << len_log) - 32'd1);
        seq_col   = (base & ~wrap_mask) | ((base + idx) & wrap_mask);
        ilv_col   = base ^ (idx & wrap_mask);
    end

    generate
        if (ILV_EN) begin : g_ilv
            assign use_ilv = ilv && !page;
        end else begin : g_seq_only
            assign use_ilv = 1'b0;
        end
    endgenerate

    // Pick the order and force zero when no beat is issued
    always_comb begin
        if (!act)         col = '0;
        else if (use_ilv) col = ilv_col;
        else              col = seq_col;
    end

endmodule

// File: rtl/sbs_rd_pipe.sv
`timescale 1ns/1ps
// Read return pipeline: delays read beats by CAS latency MIN_LAT or
// MIN_LAT+1 and delays the mask by DQM_LAT to gate output enable.
// Assumes lat_sel is stable while read beats are in flight.
module sbs_rd_pipe #(
    parameter int MIN_LAT = 2,
    parameter int DQM_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_beat,
    input  logic lat_sel,
    input  logic dqm,
    output logic rd_valid,
    output logic rd_oe
);

    localparam int MAX_LAT = MIN_LAT + 1;

    logic [MAX_LAT-1:0] vld_sh;
    logic [DQM_LAT-1:0] dqm_sh;

    // Shift read beats toward the data return cycle
    always_ff @(posedge clk) begin
        if (!rst_n) vld_sh <= '0;
        else        vld_sh <= {vld_sh[MAX_LAT-2:0], rd_beat};
    end

    generate
        if (DQM_LAT == 1) begin : g_dqm_one
            // Single-stage mask delay
            always_ff @(posedge clk) begin
                if (!rst_n) dqm_sh <= '0;
                else        dqm_sh <= dqm;
            end
        end else begin : g_dqm_multi
            // Multi-stage mask delay
            always_ff @(posedge clk) begin
                if (!rst_n) dqm_sh <= '0;
                else        dqm_sh <= {dqm_sh[DQM_LAT-2:0], dqm};
            end
        end
    endgenerate

    // Tap the selected latency and gate enable with the delayed mask
    always_comb begin
        rd_valid = lat_sel ? vld_sh[MAX_LAT-1] : vld_sh[MIN_LAT-1];
        rd_oe    = rd_valid && !dqm_sh[DQM_LAT-1];
    end

endmodule

// File: rtl/sdram_burst_seq.sv
`timescale 1ns/1ps
// SDRAM burst column sequencer top: issues per-beat column addresses,
// write accept and mask in the beat cycle, and read valid / output
// enable after the CAS latency. A new command cuts a running burst.
// Assumes cas_lat is static while reads are outstanding.
module sdram_burst_seq
    import sbs_pkg::*;
#(
    parameter int COL_W      = 9,
    parameter int CL_MIN     = 2,
    parameter int RD_DQM_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             burst_il,
    input  logic             cas_lat,
    input  logic             dqm,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             wr_accept,
    output logic             wr_mask,
    output logic             rd_valid,
    output logic             rd_oe
);

    logic             beat_act;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] beat_base;
    burst_cfg_t       beat_cfg;
    logic             rd_beat;

    sbs_beat_ctl #(.COL_W(COL_W)) u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_rd    (cmd_rd),
        .cmd_wr    (cmd_wr),
        .start_col (start_col),
        .bl_code   (bl_code),
        .burst_il  (burst_il),
        .beat_act  (beat_act),
        .beat_idx  (beat_idx),
        .beat_base (beat_base),
        .beat_cfg  (beat_cfg)
    );

    sbs_addr_gen #(.COL_W(COL_W), .ILV_EN(1'b1)) u_addr (
        .act     (beat_act),
        .base    (beat_base),
        .idx     (beat_idx),
        .ilv     (beat_cfg.ilv),
        .page    (beat_cfg.page),
        .len_log (beat_cfg.len_log),
        .col     (col_addr)
    );

    // Split beats by direction; write beats see the mask directly
    always_comb begin
        col_valid = beat_act;
        wr_accept = beat_act && beat_cfg.is_wr;
        wr_mask   = wr_accept && dqm;
        rd_beat   = beat_act && !beat_cfg.is_wr;
    end

    sbs_rd_pipe #(.MIN_LAT(CL_MIN), .DQM_LAT(RD_DQM_LAT)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_beat  (rd_beat),
        .lat_sel  (cas_lat),
        .dqm      (dqm),
        .rd_valid (rd_valid),
        .rd_oe    (rd_oe)
    );

endmodule

// File: rtl/sdram_burst_seq_chk.sv
`timescale 1ns/1ps
// Property checker for the burst column sequencer, bound to the top.
// Watches ports only; assumes CAS latency is the default pair 2/3
// and a read mask latency of 2.
module sdram_burst_seq_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_rd,
    input logic             cmd_wr,
    input logic [COL_W-1:0] start_col,
    input logic [2:0]       bl_code,
    input logic             cas_lat,
    input logic             dqm,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic             wr_accept,
    input logic             wr_mask,
    input logic             rd_valid,
    input logic             rd_oe
);

    // R2 R8 R11: a write command is taken in its own cycle at its column
    p_wr_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> (wr_accept && col_valid && col_addr == start_col));

    // R8: a read command restarts the burst at its column, not as a write
    p_rd_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && !cmd_wr) |-> (col_valid && !wr_accept && col_addr == start_col));

    // R6: unsupported length codes give a single beat
    p_single_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_rd || cmd_wr) && (bl_code == 3'd4 || bl_code == 3'd5 || bl_code == 3'd6))
        |=> (!col_valid || cmd_rd || cmd_wr));

    // R7: CAS latency 2 returns read beats two cycles later
    p_rd_cl2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_lat && $past(!cas_lat) && $past(!cas_lat, 2) && $past(rst_n, 2))
        |-> (rd_valid == $past(col_valid && !wr_accept, 2)));

    // R7: CAS latency 3 returns read beats three cycles later
    p_rd_cl3_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat && $past(cas_lat) && $past(cas_lat, 2) && $past(rst_n, 3))
        |-> (rd_valid == $past(col_valid && !wr_accept, 3)));

    // R9: write mask follows dqm in the same cycle
    p_wr_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> (wr_mask == dqm));

    // R9: no mask outside write beats
    p_wr_mask_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_accept |-> !wr_mask);

    // R10: output enable needs valid data and dqm low two cycles before
    p_rd_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (rd_valid && !$past(dqm, 2)));

    // R10: valid data with dqm low two cycles before is enabled
    p_rd_oe_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rst_n, 2) && !$past(dqm, 2)) |-> rd_oe);

    // R1: no beat means a zero column and no write accept
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (col_addr == '0 && !wr_accept));

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .start_col (start_col),
    .bl_code   (bl_code),
    .cas_lat   (cas_lat),
    .dqm       (dqm),
    .col_valid (col_valid),
    .col_addr  (col_addr),
    .wr_accept (wr_accept),
    .wr_mask   (wr_mask),
    .rd_valid  (rd_valid),
    .rd_oe     (rd_oe)
);

// File: tb/sdram_burst_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected beats and read returns,
// and the monitor pops and compares them every cycle.
module sdram_burst_seq_bench;

    localparam int PAGE = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_rd = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] bl_code = '0;
    logic       burst_il = 1'b0;
    logic       cas_lat = 1'b0;
    logic       dqm = 1'b0;
    logic       col_valid;
    logic [8:0] col_addr;
    logic       wr_accept;
    logic       wr_mask;
    logic       rd_valid;
    logic       rd_oe;

    sdram_burst_seq u_sdram_burst_seq (
        .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .start_col(start_col), .bl_code(bl_code), .burst_il(burst_il),
        .cas_lat(cas_lat), .dqm(dqm), .col_valid(col_valid),
        .col_addr(col_addr), .wr_accept(wr_accept), .wr_mask(wr_mask),
        .rd_valid(rd_valid), .rd_oe(rd_oe)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit dqm_sched [int];

    typedef struct { int cyc; int col; bit wr; string req; } beat_t;
    typedef struct { int cyc; } rdi_t;
    beat_t beat_q[$];
    rdi_t  rd_q[$];

    function automatic bit dq_at(int c);
        if (dqm_sched.exists(c)) return dqm_sched[c];
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    function automatic int bl_len(logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return PAGE;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(int col, int j, int len, bit il);
        if (len == PAGE) return (col + j) % PAGE;
        if (il) return col ^ j;
        return (col / len) * len + (((col % len) + j) % len);
    endfunction

    // Drive mask schedule every cycle
    initial forever begin
        @(negedge clk);
        dqm = dq_at(cyc);
    end

    // Driver: one command, expected beats limited by the gap to the next one
    task automatic issue(bit wr, bit both, int col, logic [2:0] code, bit il, int gap, string req);
        int c, len, n, lat;
        @(negedge clk);
        c = cyc;
        cmd_wr = wr;
        cmd_rd = !wr || both;
        start_col = 9'(col);
        bl_code = code;
        burst_il = il;
        len = bl_len(code);
        n = (len < gap) ? len : gap;
        lat = cas_lat ? 3 : 2;
        for (int j = 0; j < n; j++) begin
            beat_t b;
            b.cyc = c + j; b.col = exp_col(col, j, len, il); b.wr = wr; b.req = req;
            beat_q.push_back(b);
            if (!wr) begin
                rdi_t r;
                r.cyc = c + j + lat;
                rd_q.push_back(r);
            end
        end
        if (gap > 1) begin
            @(negedge clk);
            cmd_wr = 1'b0; cmd_rd = 1'b0;
            repeat (gap - 2) @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        cmd_wr = 1'b0; cmd_rd = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: compare outputs 1 ns before each rising edge
    initial forever begin
        @(negedge clk);
        #1.5;
        if (mon_on) begin
            if (beat_q.size() > 0 && beat_q[0].cyc == cyc) begin
                beat_t b;
                b = beat_q.pop_front();
                chk(col_valid == 1'b1, b.req, "col_valid", int'(col_valid), 1);
                chk(int'(col_addr) == b.col, b.req, "col_addr", int'(col_addr), b.col);
                chk(wr_accept == b.wr, b.req, "wr_accept", int'(wr_accept), int'(b.wr));
                chk(wr_mask == (b.wr && dq_at(cyc)), "R9", "wr_mask", int'(wr_mask),
                    int'(b.wr && dq_at(cyc)));
            end else begin
                chk(!col_valid && !wr_accept && !wr_mask && col_addr == 9'd0, "R2",
                    "idle beat outputs", int'(col_valid) + int'(wr_accept), 0);
            end
            if (rd_q.size() > 0 && rd_q[0].cyc == cyc) begin
                void'(rd_q.pop_front());
                chk(rd_valid == 1'b1, "R7", "rd_valid", int'(rd_valid), 1);
                chk(rd_oe == !dq_at(cyc - 2), "R10", "rd_oe", int'(rd_oe), int'(!dq_at(cyc - 2)));
            end else begin
                chk(!rd_valid && !rd_oe, "R7", "rd idle", int'(rd_valid), 0);
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        int c0;
        // R1: reset state
        repeat (3) begin
            @(negedge clk); #1.5;
            chk(!col_valid && !wr_accept && !wr_mask && !rd_valid && !rd_oe && col_addr == 9'd0,
                "R1", "outputs in reset", int'(col_valid | wr_accept | rd_valid | rd_oe), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(3);

        // R2 R3: sequential write BL4 from unaligned column 13 -> 13,14,15,12
        issue(1'b1, 1'b0, 13, 3'd2, 1'b0, 6, "R2 R3");
        // R3 R7: sequential read BL8, CL2
        issue(1'b0, 1'b0, 9'h1A3, 3'd3, 1'b0, 11, "R3");
        // R4: interleaved read BL4 -> 6,7,4,5
        issue(1'b0, 1'b0, 6, 3'd2, 1'b1, 7, "R4");
        // R4: interleaved write BL8 -> 5,4,7,6,1,0,3,2
        issue(1'b1, 1'b0, 5, 3'd3, 1'b1, 9, "R4");
        // R5 R8: full page from 0x1FD wraps to 0, cut by a read BL2
        issue(1'b1, 1'b0, 9'h1FD, 3'd7, 1'b1, 8, "R5");
        issue(1'b0, 1'b0, 9'h40, 3'd1, 1'b0, 6, "R8");
        // R6: unsupported codes act as BL1
        issue(1'b1, 1'b0, 9'h33, 3'd4, 1'b0, 3, "R6");
        issue(1'b0, 1'b0, 9'h34, 3'd5, 1'b0, 3, "R6");
        issue(1'b1, 1'b0, 9'h35, 3'd6, 1'b1, 3, "R6");
        issue(1'b0, 1'b0, 9'h36, 3'd0, 1'b0, 5, "R6");
        // R8: interrupts 2 and 1 cycles apart, read then write
        issue(1'b0, 1'b0, 9'h20, 3'd3, 1'b0, 2, "R8");
        issue(1'b0, 1'b0, 9'h91, 3'd2, 1'b0, 1, "R8");
        issue(1'b1, 1'b0, 9'h100, 3'd1, 1'b0, 6, "R8");
        // R11: both strobes taken as write
        issue(1'b1, 1'b1, 9'h0A, 3'd1, 1'b0, 6, "R11");
        idle(4);
        // R7: CAS latency 3
        cas_lat = 1'b1;
        idle(2);
        issue(1'b0, 1'b0, 9'h10, 3'd2, 1'b0, 9, "R7");
        issue(1'b0, 1'b0, 9'h1F, 3'd3, 1'b1, 12, "R7");
        cas_lat = 1'b0;
        idle(3);
        // R9: mask on beat 1 of a write BL4
        c0 = cyc + 1;
        dqm_sched[c0 + 1] = 1'b1;
        issue(1'b1, 1'b0, 9'h48, 3'd2, 1'b0, 7, "R9");
        // R10: mask ahead of read data (CL2 BL4 returns at c0+2..c0+5)
        c0 = cyc + 1;
        dqm_sched[c0 + 1] = 1'b1;
        dqm_sched[c0 + 3] = 1'b1;
        issue(1'b0, 1'b0, 9'h60, 3'd2, 1'b0, 9, "R10");
        idle(8);
        chk(beat_q.size() == 0 && rd_q.size() == 0, "R2", "scoreboard drained",
            beat_q.size() + rd_q.size(), 0);
        finish_run();
    end

endmodule